// File: doc/BRIEF.md
# MDIO 32-bit indirect register sequencer

This block sits between a 32-bit register client and a Clause 22 MDIO frame engine. A switch device on the management bus exposes 32-bit registers behind a paged window. The block accepts one read, write or read-modify-write request on a flat 32-bit address. It turns that request into a fixed chain of 16-bit Clause 22 commands. The chain always opens with a page-select write. The data then moves as two 16-bit halves, low half first.

The client offers a request with a valid/ready handshake. When the chain ends, the block returns a one-cycle done pulse together with an error flag and the 32-bit read value. On the engine side, each 16-bit command is held steady with a valid line until the engine acknowledges it. The acknowledge carries an error bit and, for reads, 16 bits of data. Serial pin timing is handled entirely by the engine.

Top module: `mdio32_seq`

## Requirements
- R1: The first command of every operation is a write. Its PHY address is 0x18 OR address bits [31:29], its register number is address bits [28:24], and its data is address bits [23:8].
- R2: Data commands use PHY address 0x10 OR address bits [7:5]. The low half uses register number {address[4:2], 2'b00}, and the high half uses that number with bit 1 set. The low half always goes before the high half.
- R3: Operation code 0 (read), and the reserved code 3, issue page select, then a low read, then a high read. When done_o pulses without error, rdata_o = {high, low}.
- R4: Operation code 1 (write) issues page select, then a low write of wdata[15:0], then a high write of wdata[31:16]. It issues no read.
- R5: Operation code 2 (read-modify-write) issues page select, low read, high read, low write and high write. The written word is (old AND NOT clear) OR set. rdata_o returns the old word.
- R6: If an acknowledge carries an error, no further command is issued. done_o pulses one cycle later with err_o = 1.
- R7: While cmd_valid_o is high and no acknowledge has arrived, the command fields stay stable. The block moves to the next command only on cmd_ack_i.
- R8: req_ready_o is high only while idle, and a request is taken when req_valid_i and req_ready_o are both high. done_o is a one-cycle pulse. err_o and rdata_o hold their values until the next request is accepted.
- R9: After reset, req_ready_o = 1 and cmd_valid_o, done_o, err_o and rdata_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_op_i | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| req_addr_i | input | 32 | Flat register address |
| req_wdata_i | input | 32 | Write data for a plain write |
| req_clr_i | input | 32 | Bits cleared by a read-modify-write |
| req_set_i | input | 32 | Bits set by a read-modify-write |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| err_o | output | 1 | Operation aborted by an engine error |
| rdata_o | output | 32 | Word read by a read or read-modify-write |
| cmd_valid_o | output | 1 | 16-bit command pending |
| cmd_write_o | output | 1 | Command is a write |
| cmd_phy_o | output | 5 | Command PHY address |
| cmd_reg_o | output | 5 | Command register number |
| cmd_wdata_o | output | 16 | Command write data |
| cmd_ack_i | input | 1 | Engine finished the pending command |
| cmd_err_i | input | 1 | Error status qualified by cmd_ack_i |
| cmd_rdata_i | input | 16 | Read data qualified by cmd_ack_i |

## Verification
The bench builds the block with its default PHY prefixes, 0x18 for page select and 0x10 for data. These keep the two PHY windows apart, so page writes and data halves occupy separate cells of the engine model's register array. The bench draws switch addresses from a few low values and also uses 0xFF. This reaches the top page-select PHY 0x1F and register 31, and the repeated addresses make reads return values written by earlier operations. An error is injected at every step position of a read-modify-write, so truncation is exercised after the page select, after each read and after each write.

// File: rtl/mdio32_pkg.sv
package mdio32_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAGE,
    ST_RD_LO,
    ST_RD_HI,
    ST_WR_LO,
    ST_WR_HI
  } st_e;

  typedef struct packed {
    logic [4:0]  pg_phy;
    logic [4:0]  pg_reg;
    logic [15:0] page;
    logic [4:0]  dat_phy;
    logic [4:0]  dat_reg;
  } xlate_t;
endpackage

// File: rtl/mdio32_addr_map.sv
module mdio32_addr_map
  import mdio32_pkg::*;
#(
  parameter logic [4:0] PAGE_PHY_BASE = 5'h18,
  parameter logic [4:0] DATA_PHY_BASE = 5'h10
) (
  input  logic [31:0] addr_i,
  output xlate_t      xl_o
);
  localparam int SW_LSB   = 24;
  localparam int PAGE_LSB = 8;
  localparam int SUB_LSB  = 5;

  logic [7:0] sw_addr;
  assign sw_addr = addr_i[SW_LSB +: 8];

  always_comb begin
    xl_o.pg_phy  = PAGE_PHY_BASE | {2'b00, sw_addr[7:5]};
    xl_o.pg_reg  = sw_addr[4:0];
    xl_o.page    = addr_i[PAGE_LSB +: 16];
    xl_o.dat_phy = DATA_PHY_BASE | {2'b00, addr_i[SUB_LSB +: 3]};
    xl_o.dat_reg = {addr_i[4:2], 2'b00}; // register field kept in place
  end
endmodule

// File: rtl/mdio32_word_buf.sv
module mdio32_word_buf #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] clr_i,
  input  logic [WORD_W-1:0] set_i,
  input  logic              rmw_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [HALF_W-1:0] half_i,
  output logic [WORD_W-1:0] rd_o,
  output logic [WORD_W-1:0] wr_o
);
  logic [HALF_W-1:0] rd_lo_q, rd_hi_q;
  logic [WORD_W-1:0] wdata_q, clr_q, set_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_lo_q <= '0;
      rd_hi_q <= '0;
      wdata_q <= '0;
      clr_q   <= '0;
      set_q   <= '0;
    end else if (load_i) begin
      rd_lo_q <= '0;
      rd_hi_q <= '0;
      wdata_q <= wdata_i;
      clr_q   <= clr_i;
      set_q   <= set_i;
    end else begin
      if (lo_we_i) rd_lo_q <= half_i;
      if (hi_we_i) rd_hi_q <= half_i;
    end
  end

  assign rd_o = {rd_hi_q, rd_lo_q};
  assign wr_o = rmw_i ? ((rd_o & ~clr_q) | set_q) : wdata_q;
endmodule

// File: rtl/mdio32_seq.sv
module mdio32_seq
  import mdio32_pkg::*;
#(
  parameter logic [4:0] PAGE_PHY_BASE = 5'h18,
  parameter logic [4:0] DATA_PHY_BASE = 5'h10,
  parameter int         HALF_W        = 16,
  localparam int        WORD_W        = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [31:0]       req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  input  logic [WORD_W-1:0] req_clr_i,
  input  logic [WORD_W-1:0] req_set_i,
  output logic              done_o,
  output logic              err_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              cmd_valid_o,
  output logic              cmd_write_o,
  output logic [4:0]        cmd_phy_o,
  output logic [4:0]        cmd_reg_o,
  output logic [HALF_W-1:0] cmd_wdata_o,
  input  logic              cmd_ack_i,
  input  logic              cmd_err_i,
  input  logic [HALF_W-1:0] cmd_rdata_i
);
  st_e    st_q, st_d;
  op_e    op_q;
  xlate_t xl_in, xl_q;
  logic   done_q, err_q, accept, step_ok;
  logic [WORD_W-1:0] wr_word;

  mdio32_addr_map #(
    .PAGE_PHY_BASE(PAGE_PHY_BASE),
    .DATA_PHY_BASE(DATA_PHY_BASE)
  ) u_addr_map (
    .addr_i (req_addr_i),
    .xl_o   (xl_in)
  );

  assign accept  = (st_q == ST_IDLE) && req_valid_i;
  assign step_ok = cmd_valid_o && cmd_ack_i && !cmd_err_i;

  mdio32_word_buf #(.HALF_W(HALF_W)) u_word_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .wdata_i (req_wdata_i),
    .clr_i   (req_clr_i),
    .set_i   (req_set_i),
    .rmw_i   (op_q == OP_RMW),
    .lo_we_i (step_ok && st_q == ST_RD_LO),
    .hi_we_i (step_ok && st_q == ST_RD_HI),
    .half_i  (cmd_rdata_i),
    .rd_o    (rdata_o),
    .wr_o    (wr_word)
  );

  always_comb begin
    unique case (st_q)
      ST_PAGE:  st_d = (op_q == OP_WRITE) ? ST_WR_LO : ST_RD_LO;
      ST_RD_LO: st_d = ST_RD_HI;
      ST_RD_HI: st_d = (op_q == OP_RMW) ? ST_WR_LO : ST_IDLE;
      ST_WR_LO: st_d = ST_WR_HI;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_READ;
      xl_q   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        st_q  <= ST_PAGE;
        op_q  <= op_e'(req_op_i);
        xl_q  <= xl_in;
        err_q <= 1'b0;
      end else if (st_q != ST_IDLE && cmd_ack_i) begin
        if (cmd_err_i) begin
          st_q   <= ST_IDLE;
          err_q  <= 1'b1;
          done_q <= 1'b1;
        end else begin
          st_q <= st_d;
          if (st_d == ST_IDLE) done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    cmd_write_o = 1'b0;
    cmd_phy_o   = xl_q.dat_phy;
    cmd_reg_o   = xl_q.dat_reg;
    cmd_wdata_o = '0;
    unique case (st_q)
      ST_PAGE: begin
        cmd_write_o = 1'b1;
        cmd_phy_o   = xl_q.pg_phy;
        cmd_reg_o   = xl_q.pg_reg;
        cmd_wdata_o = xl_q.page;
      end
      ST_RD_HI: cmd_reg_o = xl_q.dat_reg | 5'd2;
      ST_WR_LO: begin
        cmd_write_o = 1'b1;
        cmd_wdata_o = wr_word[HALF_W-1:0];
      end
      ST_WR_HI: begin
        cmd_write_o = 1'b1;
        cmd_reg_o   = xl_q.dat_reg | 5'd2;
        cmd_wdata_o = wr_word[WORD_W-1:HALF_W];
      end
      default: ;
    endcase
  end

  assign cmd_valid_o = (st_q != ST_IDLE);
  assign req_ready_o = (st_q == ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ack_i |=> cmd_valid_o && $stable(cmd_phy_o) && $stable(cmd_reg_o)
      && $stable(cmd_write_o) && $stable(cmd_wdata_o)); // R7
  AST_ERR_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ack_i && cmd_err_i |=> !cmd_valid_o && done_o && err_o); // R6
  AST_PAGE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> cmd_write_o && cmd_phy_o == (PAGE_PHY_BASE | {2'b00, cmd_phy_o[2:0]})); // R1
  AST_HIGH_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_ok && (st_q == ST_RD_LO || st_q == ST_WR_LO) |=>
      cmd_valid_o && cmd_reg_o == ($past(cmd_reg_o) | 5'd2) && cmd_write_o == $past(cmd_write_o)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(rdata_o) || cmd_valid_o || $past(cmd_valid_o)); // R8
endmodule

// File: tb/mdio32_seq_bench.sv
module mdio32_seq_bench;
  typedef struct packed {
    logic        w;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] d;
  } cmd_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [1:0]  req_op_i = '0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0, req_clr_i = '0, req_set_i = '0;
  logic        done_o, err_o;
  logic [31:0] rdata_o;
  logic        cmd_valid_o, cmd_write_o;
  logic [4:0]  cmd_phy_o, cmd_reg_o;
  logic [15:0] cmd_wdata_o;
  logic        cmd_ack_i, cmd_err_i;
  logic [15:0] cmd_rdata_i;

  int checks = 0;
  int errors = 0;
  int cur_err_at = 99;
  int cmd_idx = 0;
  cmd_t exp_q[$];
  logic [15:0] mem [0:1023];
  logic [15:0] ref_mem [0:1023];

  always #4 clk_i = ~clk_i;

  mdio32_seq u_mdio32_seq (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // engine model and command monitor
  initial begin
    cmd_t got, e;
    int lat;
    cmd_ack_i = 1'b0; cmd_err_i = 1'b0; cmd_rdata_i = '0;
    forever begin
      @(negedge clk_i);
      if (rst_ni && cmd_valid_o) begin
        got = '{cmd_write_o, cmd_phy_o, cmd_reg_o, cmd_wdata_o};
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected command", 32'(got), 32'h0);
        end else begin
          e = exp_q.pop_front();
          chk(got.w == e.w && got.phy == e.phy && got.rg == e.rg && (!e.w || got.d == e.d),
              (cmd_idx == 0) ? "R1 page command" : "R2 data command", 32'(got), 32'(e));
        end
        lat = $urandom_range(0, 3);
        for (int i = 0; i < lat; i++) begin
          @(negedge clk_i);
          chk(cmd_valid_o && cmd_write_o == got.w && cmd_phy_o == got.phy && cmd_reg_o == got.rg
              && cmd_wdata_o == got.d, "R7 hold", {cmd_phy_o, cmd_reg_o, cmd_wdata_o},
              {got.phy, got.rg, got.d});
        end
        cmd_rdata_i = mem[{got.phy, got.rg}];
        cmd_err_i   = (cmd_idx == cur_err_at);
        cmd_ack_i   = 1'b1;
        if (got.w && !cmd_err_i) mem[{got.phy, got.rg}] = got.d;
        @(negedge clk_i);
        cmd_ack_i = 1'b0;
        cmd_err_i = 1'b0;
        cmd_idx++;
      end
    end
  end

  task automatic do_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] wd,
                       input logic [31:0] cl, input logic [31:0] st, input int err_at);
    logic [4:0]  pg_phy, pg_reg, dphy, dreg, hreg;
    logic [31:0] rv, nv;
    logic        stop;
    int          k;
    string       tag;
    pg_phy = 5'h18 | {2'b00, a[31:29]};
    pg_reg = a[28:24];
    dphy   = 5'h10 | {2'b00, a[7:5]};
    dreg   = {a[4:2], 2'b00};
    hreg   = dreg | 5'd2;
    tag    = (op == 2'd1) ? "R4" : (op == 2'd2) ? "R5" : "R3";
    stop   = 1'b0;
    rv     = '0;
    exp_q.push_back('{1'b1, pg_phy, pg_reg, a[23:8]});
    if (err_at == 0) stop = 1'b1; else ref_mem[{pg_phy, pg_reg}] = a[23:8];
    k = 1;
    if (op != 2'd1) begin
      rv = {ref_mem[{dphy, hreg}], ref_mem[{dphy, dreg}]};
      if (!stop) begin exp_q.push_back('{1'b0, dphy, dreg, 16'h0}); if (err_at == k) stop = 1'b1; k++; end
      if (!stop) begin exp_q.push_back('{1'b0, dphy, hreg, 16'h0}); if (err_at == k) stop = 1'b1; k++; end
    end
    if (op == 2'd1 || op == 2'd2) begin
      nv = (op == 2'd2) ? ((rv & ~cl) | st) : wd;
      if (!stop) begin
        exp_q.push_back('{1'b1, dphy, dreg, nv[15:0]});
        if (err_at == k) stop = 1'b1; else ref_mem[{dphy, dreg}] = nv[15:0];
        k++;
      end
      if (!stop) begin
        exp_q.push_back('{1'b1, dphy, hreg, nv[31:16]});
        if (err_at == k) stop = 1'b1; else ref_mem[{dphy, hreg}] = nv[31:16];
        k++;
      end
    end
    cur_err_at = err_at;
    cmd_idx    = 0;
    @(negedge clk_i);
    chk(req_ready_o, "R8 ready when idle", 32'(req_ready_o), 32'h1);
    req_op_i = op; req_addr_i = a; req_wdata_i = wd; req_clr_i = cl; req_set_i = st;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(!req_ready_o && cmd_valid_o, "R8 busy after accept", 32'(req_ready_o), 32'h0);
    while (!done_o) @(negedge clk_i);
    chk(err_o == stop, stop ? "R6 error flag" : {tag, " error flag"}, 32'(err_o), 32'(stop));
    chk(exp_q.size() == 0, stop ? "R6 truncated sequence" : {tag, " all commands"}, exp_q.size(), 0);
    exp_q.delete();
    if (!stop && op != 2'd1)
      chk(rdata_o == rv, {tag, " read data"}, rdata_o, rv);
    rv = rdata_o;
    @(negedge clk_i);
    chk(!done_o && err_o == stop && rdata_o == rv && !cmd_valid_o, "R8 pulse and hold",
        {done_o, err_o, rdata_o[29:0]}, {1'b0, stop, rv[29:0]});
  endtask

  initial begin
    logic [31:0] a;
    logic [31:0] p;
    int bad;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 16'(i * 16'h9E37 + 16'h1234);
      ref_mem[i] = mem[i];
    end
    void'($urandom(7));
    repeat (3) @(negedge clk_i);
    chk(req_ready_o && !cmd_valid_o && !done_o && !err_o && rdata_o == 0, "R9 reset state",
        {req_ready_o, cmd_valid_o, done_o, err_o}, 32'h8);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !cmd_valid_o && !done_o && !err_o && rdata_o == 0, "R9 after release",
        {req_ready_o, cmd_valid_o, done_o, err_o}, 32'h8);

    // directed
    do_op(2'd1, 32'h0112_34A8, 32'hDEAD_BEEF, 0, 0, 99);          // R4
    do_op(2'd0, 32'h0155_66A8, 0, 0, 0, 99);                      // R3 same cell, other page
    do_op(2'd2, 32'h0112_34A8, 0, 32'h0000_FF00, 32'h8000_0001, 99); // R5
    do_op(2'd3, 32'h0112_34A8, 0, 0, 0, 99);                      // R3 reserved code
    do_op(2'd1, 32'hFFAB_CDFC, 32'h0F0F_5A5A, 0, 0, 99);          // R1 switch address 0xFF
    do_op(2'd0, 32'hFFAB_CDFC, 0, 0, 0, 99);
    for (int s = 0; s < 5; s++)                                     // R6 every step
      do_op(2'd2, 32'h0300_0044, 0, 32'hFFFF_0000, 32'h1234_0000, s);
    do_op(2'd0, 32'h0300_0044, 0, 0, 0, 2);                         // R6 on high read
    // random
    for (int n = 0; n < 60; n++) begin
      p = $urandom;
      a = {6'b0, p[1:0], p[17:2], p[20:18], p[23:21], 2'b00};
      do_op(2'($urandom_range(0, 3)), a, $urandom, $urandom, $urandom,
            ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 4)) : 99);
    end
    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk(bad == 0, "R5 final register contents", bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule